// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 16-bit processor whose datapath shares one bus. A 6-bit micro-address register selects a word in a control store. Each word gives every datapath control line for that cycle and tells the sequencer how to pick the next micro-address. The options are to step to a fixed successor, to wait on memory, to branch on a condition, or to dispatch on the instruction opcode.

Every instruction starts with a common four-step fetch. Fetch ends in a decode step, which jumps to the first word of the execute routine for the opcode. The supported opcodes are add, and, not, direct load, base-relative load, store, conditional branch, register jump, and a custom load whose address is the sum of two registers. When an execute routine finishes, control returns to the first fetch word. Program execution begins at address 0x0000, which the datapath's program counter holds after reset.

The control store is read synchronously at the next micro-address, so every control output comes straight from a flop. An opcode with no routine sends the sequencer to a halt word. The halt word drives nothing, and only reset leaves it.

Top module: `mseq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the outputs show the first fetch word: gate_pc, ld_mar and ld_pc high with pc_sel=00, everything else low, and halted low.
- R2: Fetch runs four micro-states. The first is as in R1. The second is a memory read (mem_en=1, mem_wr=0, mdr_sel=1, ld_mdr=1). The third drives the MDR onto the bus into IR (gate_mdr, ld_ir). The fourth, the decode step, has all controls low.
- R3: At decode the opcode selects the routine: 0001 add, 0101 and, 1001 not, 0010 load, 0110 base load, 0011 store, 0000 branch, 1100 jump, 1101 summed-register load.
- R4: At most one of gate_pc, gate_mdr, gate_alu and gate_marmux is high in any cycle.
- R5: A memory micro-state repeats with unchanged outputs until mem_ready is sampled high. A read has mem_en=1 and mem_wr=0. A write has mem_en=1 and mem_wr=1. mem_wr is never high without mem_en.
- R6: Whenever ld_mdr is high, mdr_sel equals mem_en (0 selects the bus, 1 selects memory data).
- R7: ld_cc is high only in a cycle where ld_reg is high. It is high for add, and, not, load and base load, and stays low for the summed-register load.
- R8: Add, and and not each take one cycle with gate_alu, ld_reg and ld_cc high, and alu_op 00, 01 or 10 respectively.
- R9: Load first drives the address adder through the MAR mux into MAR (gate_marmux, ld_mar, marmux_sel=1). The adder uses addr1_sel=0 (PC) and addr2_sel=10 (9-bit offset). A read follows (R5), then gate_mdr with ld_reg and ld_cc. Base load is the same but with addr1_sel=1 (base register) and addr2_sel=01 (6-bit offset).
- R10: Store forms its address as load does. It then drives the register through ALU pass-A (alu_op=11, gate_alu) into MDR with mdr_sel=0, and then performs a write (R5).
- R11: Branch spends one cycle with all controls low. If branch_ok is high at its end, a second cycle loads the PC from the adder (ld_pc, pc_sel=01, addr1_sel=0, addr2_sel=10). Otherwise fetch resumes.
- R12: Jump takes one cycle with alu_op=11, gate_alu, pc_sel=10 and ld_pc.
- R13: Summed-register load drives the ALU sum (alu_op=00, gate_alu) into MAR, then reads, then drives gate_mdr with ld_reg.
- R14: After the last step of each execute routine the next cycle is the first fetch word. Any other opcode leads from decode to a halt where halted is high and every control is low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| mem_ready | input | 1 | Memory has completed the current access |
| branch_ok | input | 1 | Condition codes satisfy the branch instruction |
| ld_mar | output | 1 | Load memory address register from bus |
| ld_mdr | output | 1 | Load memory data register |
| ld_ir | output | 1 | Load instruction register from bus |
| ld_reg | output | 1 | Write destination register from bus |
| ld_cc | output | 1 | Update condition codes from bus |
| ld_pc | output | 1 | Load program counter |
| gate_pc | output | 1 | Drive PC onto bus |
| gate_mdr | output | 1 | Drive MDR onto bus |
| gate_alu | output | 1 | Drive ALU result onto bus |
| gate_marmux | output | 1 | Drive MAR mux onto bus |
| pc_sel | output | 2 | PC source: 00 increment, 01 adder, 10 bus |
| alu_op | output | 2 | 00 add, 01 and, 10 not A, 11 pass A |
| addr1_sel | output | 1 | Adder base: 0 PC, 1 base register |
| addr2_sel | output | 2 | Adder offset: 00 zero, 01 6-bit, 10 9-bit, 11 11-bit |
| marmux_sel | output | 1 | MAR mux: 1 adder output |
| mem_en | output | 1 | Memory access enable |
| mem_wr | output | 1 | Memory write (1) or read (0) |
| mdr_sel | output | 1 | MDR source: 0 bus, 1 memory |
| halted | output | 1 | Sequencer is parked in the halt word |

## Verification
A corrupted micro-address becomes visible on the control outputs at the next clock edge. The outputs are registered copies of the control word at the current address, so any off-sequence step appears as a wrong control pattern in the very cycle it takes effect. A wrong dispatch shows one cycle after decode as the wrong first execute word. A wait that is not held, or not released, shows as a memory step that is too short or repeats past a sampled mem_ready. A missed return to fetch shows as a missing gate_pc/ld_mar pair one cycle after the last execute step.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int UA_W  = 6;
  localparam int OPC_W = 4;

  typedef logic [UA_W-1:0]  uaddr_t;
  typedef logic [OPC_W-1:0] opc_t;

  typedef enum logic [1:0] {SQ_NEXT, SQ_WAIT, SQ_DISP, SQ_COND} seq_e;

  typedef struct packed {
    logic       ld_mar;
    logic       ld_mdr;
    logic       ld_ir;
    logic       ld_reg;
    logic       ld_cc;
    logic       ld_pc;
    logic       gate_pc;
    logic       gate_mdr;
    logic       gate_alu;
    logic       gate_marmux;
    logic [1:0] pc_sel;
    logic [1:0] alu_op;
    logic       addr1_sel;
    logic [1:0] addr2_sel;
    logic       marmux_sel;
    logic       mem_en;
    logic       mem_wr;
    logic       mdr_sel;
    seq_e       seq;
    uaddr_t     nxt;
  } uword_t;

  // micro-addresses
  localparam uaddr_t UA_F0   = 6'd0;
  localparam uaddr_t UA_F1   = 6'd1;
  localparam uaddr_t UA_F2   = 6'd2;
  localparam uaddr_t UA_DEC  = 6'd3;
  localparam uaddr_t UA_ADD  = 6'd4;
  localparam uaddr_t UA_AND  = 6'd5;
  localparam uaddr_t UA_NOT  = 6'd6;
  localparam uaddr_t UA_LD0  = 6'd8;
  localparam uaddr_t UA_LD1  = 6'd9;
  localparam uaddr_t UA_LD2  = 6'd10;
  localparam uaddr_t UA_LR0  = 6'd12;
  localparam uaddr_t UA_LR1  = 6'd13;
  localparam uaddr_t UA_LR2  = 6'd14;
  localparam uaddr_t UA_ST0  = 6'd16;
  localparam uaddr_t UA_ST1  = 6'd17;
  localparam uaddr_t UA_ST2  = 6'd18;
  localparam uaddr_t UA_BR0  = 6'd20;
  localparam uaddr_t UA_BR1  = 6'd21;
  localparam uaddr_t UA_JMP  = 6'd24;
  localparam uaddr_t UA_SM0  = 6'd28;
  localparam uaddr_t UA_SM1  = 6'd29;
  localparam uaddr_t UA_SM2  = 6'd30;
  localparam uaddr_t UA_HALT = 6'd63;

  // opcode encodings the dispatch depends on
  localparam opc_t OP_BR  = 4'b0000;
  localparam opc_t OP_ADD = 4'b0001;
  localparam opc_t OP_LD  = 4'b0010;
  localparam opc_t OP_ST  = 4'b0011;
  localparam opc_t OP_AND = 4'b0101;
  localparam opc_t OP_LDR = 4'b0110;
  localparam opc_t OP_NOT = 4'b1001;
  localparam opc_t OP_JMP = 4'b1100;
  localparam opc_t OP_SUM = 4'b1101;

  function automatic uaddr_t dispatch(opc_t op);
    case (op)
      OP_BR:   return UA_BR0;
      OP_ADD:  return UA_ADD;
      OP_LD:   return UA_LD0;
      OP_ST:   return UA_ST0;
      OP_AND:  return UA_AND;
      OP_LDR:  return UA_LR0;
      OP_NOT:  return UA_NOT;
      OP_JMP:  return UA_JMP;
      OP_SUM:  return UA_SM0;
      default: return UA_HALT;
    endcase
  endfunction

  // control store contents, computed per address
  function automatic uword_t uword_at(uaddr_t a);
    uword_t w;
    w     = '0;
    w.seq = SQ_NEXT;
    w.nxt = UA_F0;
    case (a)
      UA_F0: begin
        w.gate_pc = 1'b1; w.ld_mar = 1'b1; w.ld_pc = 1'b1; w.pc_sel = 2'b00;
        w.nxt = UA_F1;
      end
      UA_F1, UA_LD1, UA_LR1, UA_SM1: begin
        w.mem_en = 1'b1; w.mdr_sel = 1'b1; w.ld_mdr = 1'b1; w.seq = SQ_WAIT;
        w.nxt = (a == UA_F1) ? UA_F2 : a + 6'd1;
      end
      UA_F2: begin
        w.gate_mdr = 1'b1; w.ld_ir = 1'b1; w.nxt = UA_DEC;
      end
      UA_DEC: w.seq = SQ_DISP;
      UA_ADD, UA_AND, UA_NOT: begin
        w.gate_alu = 1'b1; w.ld_reg = 1'b1; w.ld_cc = 1'b1;
        w.alu_op = (a == UA_ADD) ? 2'b00 : (a == UA_AND) ? 2'b01 : 2'b10;
      end
      UA_LD0, UA_ST0: begin
        w.gate_marmux = 1'b1; w.marmux_sel = 1'b1; w.ld_mar = 1'b1;
        w.addr1_sel = 1'b0; w.addr2_sel = 2'b10; w.nxt = a + 6'd1;
      end
      UA_LR0: begin
        w.gate_marmux = 1'b1; w.marmux_sel = 1'b1; w.ld_mar = 1'b1;
        w.addr1_sel = 1'b1; w.addr2_sel = 2'b01; w.nxt = UA_LR1;
      end
      UA_LD2, UA_LR2: begin
        w.gate_mdr = 1'b1; w.ld_reg = 1'b1; w.ld_cc = 1'b1;
      end
      UA_ST1: begin
        w.alu_op = 2'b11; w.gate_alu = 1'b1; w.ld_mdr = 1'b1; w.mdr_sel = 1'b0;
        w.nxt = UA_ST2;
      end
      UA_ST2: begin
        w.mem_en = 1'b1; w.mem_wr = 1'b1; w.mdr_sel = 1'b1; w.seq = SQ_WAIT;
      end
      UA_BR0: begin
        w.seq = SQ_COND; w.nxt = UA_BR1;
      end
      UA_BR1: begin
        w.ld_pc = 1'b1; w.pc_sel = 2'b01; w.addr1_sel = 1'b0; w.addr2_sel = 2'b10;
      end
      UA_JMP: begin
        w.alu_op = 2'b11; w.gate_alu = 1'b1; w.pc_sel = 2'b10; w.ld_pc = 1'b1;
      end
      UA_SM0: begin
        w.alu_op = 2'b00; w.gate_alu = 1'b1; w.ld_mar = 1'b1; w.nxt = UA_SM1;
      end
      UA_SM2: begin
        w.gate_mdr = 1'b1; w.ld_reg = 1'b1;
      end
      default: w.nxt = UA_HALT;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
(
  input  logic   clk,
  input  uaddr_t addr,
  output uword_t word
);
  // synchronous read so the store maps onto a block RAM
  always_ff @(posedge clk) begin
    word <= uword_at(addr);
  end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
(
  input  uword_t cur,
  input  uaddr_t state,
  input  opc_t   opcode,
  input  logic   mem_ready,
  input  logic   branch_ok,
  output uaddr_t nxt
);
  always_comb begin
    unique case (cur.seq)
      SQ_NEXT: nxt = cur.nxt;
      SQ_WAIT: nxt = mem_ready ? cur.nxt : state;
      SQ_DISP: nxt = dispatch(opcode);
      SQ_COND: nxt = branch_ok ? cur.nxt : UA_F0;
      default: nxt = UA_HALT;
    endcase
  end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  input  logic       mem_ready,
  input  logic       branch_ok,
  output logic       ld_mar,
  output logic       ld_mdr,
  output logic       ld_ir,
  output logic       ld_reg,
  output logic       ld_cc,
  output logic       ld_pc,
  output logic       gate_pc,
  output logic       gate_mdr,
  output logic       gate_alu,
  output logic       gate_marmux,
  output logic [1:0] pc_sel,
  output logic [1:0] alu_op,
  output logic       addr1_sel,
  output logic [1:0] addr2_sel,
  output logic       marmux_sel,
  output logic       mem_en,
  output logic       mem_wr,
  output logic       mdr_sel,
  output logic       halted
);
  uaddr_t state_q;
  uaddr_t nxt_state;
  uaddr_t rom_addr;
  uword_t word;
  logic   halted_q;

  mseq_next u_next (
    .cur       (word),
    .state     (state_q),
    .opcode    (opcode),
    .mem_ready (mem_ready),
    .branch_ok (branch_ok),
    .nxt       (nxt_state)
  );

  assign rom_addr = rst ? UA_F0 : nxt_state;

  mseq_rom u_rom (
    .clk  (clk),
    .addr (rom_addr),
    .word (word)
  );

  always_ff @(posedge clk) begin
    state_q  <= rom_addr;
    halted_q <= (rom_addr == UA_HALT);
  end

  assign ld_mar      = word.ld_mar;
  assign ld_mdr      = word.ld_mdr;
  assign ld_ir       = word.ld_ir;
  assign ld_reg      = word.ld_reg;
  assign ld_cc       = word.ld_cc;
  assign ld_pc       = word.ld_pc;
  assign gate_pc     = word.gate_pc;
  assign gate_mdr    = word.gate_mdr;
  assign gate_alu    = word.gate_alu;
  assign gate_marmux = word.gate_marmux;
  assign pc_sel      = word.pc_sel;
  assign alu_op      = word.alu_op;
  assign addr1_sel   = word.addr1_sel;
  assign addr2_sel   = word.addr2_sel;
  assign marmux_sel  = word.marmux_sel;
  assign mem_en      = word.mem_en;
  assign mem_wr      = word.mem_wr;
  assign mdr_sel     = word.mdr_sel;
  assign halted      = halted_q;
endmodule

// File: rtl/mseq_ctrl_chk.sv
module mseq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic mem_ready,
  input logic ld_mar,
  input logic ld_mdr,
  input logic ld_ir,
  input logic ld_reg,
  input logic ld_cc,
  input logic ld_pc,
  input logic gate_pc,
  input logic gate_mdr,
  input logic gate_alu,
  input logic gate_marmux,
  input logic mem_en,
  input logic mem_wr,
  input logic mdr_sel,
  input logic halted
);
  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gate_pc && ld_mar && ld_pc && !halted));

  a_r2_ir_from_mdr: assert property (@(posedge clk) disable iff (rst)
    ld_ir |-> gate_mdr);

  a_r4_one_gate: assert property (@(posedge clk) disable iff (rst)
    $countones({gate_pc, gate_mdr, gate_alu, gate_marmux}) <= 1);

  a_r5_wr_needs_en: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_en);

  a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_ready) |=> (mem_en && $stable({mem_wr, ld_mdr, mdr_sel})));

  a_r6_mdr_src: assert property (@(posedge clk) disable iff (rst)
    ld_mdr |-> (mdr_sel == mem_en));

  a_r7_cc_with_reg: assert property (@(posedge clk) disable iff (rst)
    ld_cc |-> ld_reg);

  a_r14_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r14_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !(ld_mar || ld_mdr || ld_ir || ld_reg || ld_cc || ld_pc ||
                 gate_pc || gate_mdr || gate_alu || gate_marmux || mem_en));
endmodule

bind mseq_ctrl mseq_ctrl_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .mem_ready   (mem_ready),
  .ld_mar      (ld_mar),
  .ld_mdr      (ld_mdr),
  .ld_ir       (ld_ir),
  .ld_reg      (ld_reg),
  .ld_cc       (ld_cc),
  .ld_pc       (ld_pc),
  .gate_pc     (gate_pc),
  .gate_mdr    (gate_mdr),
  .gate_alu    (gate_alu),
  .gate_marmux (gate_marmux),
  .mem_en      (mem_en),
  .mem_wr      (mem_wr),
  .mdr_sel     (mdr_sel),
  .halted      (halted)
);

// File: tb/mseq_ctrl_tb.sv
module mseq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = 4'b0000;
  logic       mem_ready = 1'b0;
  logic       branch_ok = 1'b0;
  logic ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc, ld_pc;
  logic gate_pc, gate_mdr, gate_alu, gate_marmux;
  logic [1:0] pc_sel, alu_op, addr2_sel;
  logic addr1_sel, marmux_sel, mem_en, mem_wr, mdr_sel, halted;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mseq_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .mem_ready(mem_ready), .branch_ok(branch_ok),
    .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_reg(ld_reg), .ld_cc(ld_cc),
    .ld_pc(ld_pc), .gate_pc(gate_pc), .gate_mdr(gate_mdr), .gate_alu(gate_alu),
    .gate_marmux(gate_marmux), .pc_sel(pc_sel), .alu_op(alu_op), .addr1_sel(addr1_sel),
    .addr2_sel(addr2_sel), .marmux_sel(marmux_sel), .mem_en(mem_en), .mem_wr(mem_wr),
    .mdr_sel(mdr_sel), .halted(halted)
  );

  // observed control vector, bit 20 = ld_mar ... bit 0 = mdr_sel
  wire [20:0] obs = {ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc, ld_pc, gate_pc, gate_mdr,
                     gate_alu, gate_marmux, pc_sel, alu_op, addr1_sel, addr2_sel,
                     marmux_sel, mem_en, mem_wr, mdr_sel};

  localparam logic [20:0] M_LMAR = 21'd1 << 20, M_LMDR = 21'd1 << 19, M_LIR = 21'd1 << 18,
                          M_LREG = 21'd1 << 17, M_LCC = 21'd1 << 16, M_LPC = 21'd1 << 15,
                          M_GPC = 21'd1 << 14, M_GMDR = 21'd1 << 13, M_GALU = 21'd1 << 12,
                          M_GMM = 21'd1 << 11, M_A1 = 21'd1 << 6, M_MMX = 21'd1 << 3,
                          M_MEN = 21'd1 << 2, M_MWR = 21'd1 << 1, M_MDRS = 21'd1;

  function automatic logic [20:0] f_pcs(int v);  return 21'(v) << 9; endfunction
  function automatic logic [20:0] f_alu(int v);  return 21'(v) << 7; endfunction
  function automatic logic [20:0] f_a2(int v);   return 21'(v) << 4; endfunction

  localparam logic [20:0] W_READ = M_MEN | M_MDRS | M_LMDR;

  // returns {last, wait, vector}; fetch steps 0..3, execute from step 4
  function automatic logic [22:0] expect_at(logic [3:0] op, bit taken, int s);
    logic [20:0] v = '0; bit w = 0; bit l = 0; int e = s - 4;
    case (s)
      0: v = M_GPC | M_LMAR | M_LPC | f_pcs(0);
      1: begin v = W_READ; w = 1; end
      2: v = M_GMDR | M_LIR;
      3: v = '0;
      default: case (op)
        4'b0001: begin v = M_GALU | M_LREG | M_LCC | f_alu(0); l = 1; end
        4'b0101: begin v = M_GALU | M_LREG | M_LCC | f_alu(1); l = 1; end
        4'b1001: begin v = M_GALU | M_LREG | M_LCC | f_alu(2); l = 1; end
        4'b0010, 4'b0110: begin
          if (e == 0) v = M_GMM | M_LMAR | M_MMX | ((op == 4'b0110) ? (M_A1 | f_a2(1)) : f_a2(2));
          else if (e == 1) begin v = W_READ; w = 1; end
          else begin v = M_GMDR | M_LREG | M_LCC; l = 1; end
        end
        4'b0011: begin
          if (e == 0) v = M_GMM | M_LMAR | M_MMX | f_a2(2);
          else if (e == 1) v = f_alu(3) | M_GALU | M_LMDR;
          else begin v = M_MEN | M_MWR | M_MDRS; w = 1; l = 1; end
        end
        4'b0000: begin
          if (e == 0) begin v = '0; l = !taken; end
          else begin v = M_LPC | f_pcs(1) | f_a2(2); l = 1; end
        end
        4'b1100: begin v = f_alu(3) | M_GALU | f_pcs(2) | M_LPC; l = 1; end
        4'b1101: begin
          if (e == 0) v = f_alu(0) | M_GALU | M_LMAR;
          else if (e == 1) begin v = W_READ; w = 1; end
          else begin v = M_GMDR | M_LREG; l = 1; end
        end
        default: begin v = '0; l = 1; end
      endcase
    endcase
    return {l, w, v};
  endfunction

  function automatic string req_of(logic [3:0] op, int s);
    if (s < 4) return "R2";
    case (op)
      4'b0001, 4'b0101, 4'b1001: return "R8";
      4'b0010, 4'b0110: return "R9";
      4'b0011: return "R10";
      4'b0000: return "R11";
      4'b1100: return "R12";
      4'b1101: return "R13";
      default: return "R3";
    endcase
  endfunction

  task automatic check_vec(string req, logic [20:0] exp_v, bit exp_h);
    n_chk++;
    if (obs !== exp_v || halted !== exp_h) begin
      n_bad++;
      $display("FAIL %s: ctrl=%h halted=%b expected ctrl=%h halted=%b", req, obs, halted, exp_v, exp_h);
    end
  endtask

  // called at a negedge; leaves at a negedge with the next fetch word showing
  task automatic run_instr(logic [3:0] op, bit taken);
    int s = 0; bit done = 0; int waited = 0;
    opcode = op; branch_ok = taken;
    while (!done) begin
      logic [22:0] e; bit mr;
      e = expect_at(op, taken, s);
      check_vec(req_of(op, s), e[20:0], 1'b0);
      mr = ($urandom % 3) != 0 || waited >= 4;
      mem_ready = mr;
      @(posedge clk); @(negedge clk);
      if (!e[21] || mr) begin
        waited = 0;
        if (e[22]) done = 1; else s++;
      end else waited++;
    end
    // R14: return to fetch after the last step
    check_vec("R14", M_GPC | M_LMAR | M_LPC, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_vec("R1", M_GPC | M_LMAR | M_LPC, 1'b0);
    rst = 1'b0;
  endtask

  task automatic run_halt(logic [3:0] op);
    opcode = op;
    for (int s = 0; s < 4; s++) begin
      logic [22:0] e;
      e = expect_at(op, 1'b0, s);
      check_vec("R2", e[20:0], 1'b0);
      mem_ready = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      check_vec("R14", '0, 1'b1);
      mem_ready = k[0];
      opcode = 4'b0001;
      @(posedge clk); @(negedge clk);
    end
    do_reset();
  endtask

  localparam logic [3:0] SUP [9] = '{4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b0110,
                                      4'b0011, 4'b0000, 4'b1100, 4'b1101};
  localparam logic [3:0] BAD [7] = '{4'b0100, 4'b0111, 4'b1000, 4'b1010, 4'b1011,
                                      4'b1110, 4'b1111};

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // directed: each routine once, branch both ways
    for (int i = 0; i < 9; i++) run_instr(SUP[i], 1'b1);
    run_instr(4'b0000, 1'b0);
    run_halt(4'b1111);
    run_halt(4'b0100);
    // random mix
    for (int i = 0; i < 200; i++) begin
      int k = int'($urandom % 9);
      run_instr(SUP[k], bit'($urandom % 2));
      if (($urandom % 40) == 0) run_halt(BAD[$urandom % 7]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule